// File: doc/BRIEF.md
# Delay-Lock Reset and Write-Recovery Command Guard

This block holds the first mode register of a DRAM device model and turns two of its fields into command-timing guards. A write to the register that sets the delay-lock reset bit starts a lock window. While it runs, read commands are refused. The reset bit is never stored, so reading the register back always shows it as zero. The lock window has a fixed length, and clock enable must stay high for all of it. If clock enable drops, the window starts over and a sticky violation flag is raised.

The write-recovery field selects how many cycles must pass between the end of a write burst and a precharge. Only six field codes are legal. The other two raise a flag, and the guard then falls back to the longest legal spacing.

A controller uses the block by polling the three allow flags (read, write, precharge) before it issues a command. It presents read and write commands on the request inputs. A read asked for during the lock window is refused and latched in a sticky error flag. Software clears the sticky flags with a one-cycle clear pulse.

Top module: `modereg_timing_guard`

## Requirements
- R1: After reset, the register reads 0, `lock_busy`, `rd_err`, `cke_viol` and `wr_illegal` (code 000 reads as illegal, so `wr_illegal` is 1) behave as stated here, and with `cke` high `rd_ok`, `wr_ok` and `pre_ok` are 1.
- R2: Register bit 8 (delay-lock reset) is never stored, so `cfg_rdata[8]` is always 0. All other written bits read back unchanged.
- R3: A register write with bit 8 set makes `rd_ok` 0 for exactly LOCK_CYC cycles, counted from the clock edge that takes the write. `lock_busy` is 1 for the same cycles.
- R4: If `cke` is low at a clock edge during the lock window, the count restarts. `rd_ok` then returns LOCK_CYC cycles after that edge.
- R5: `cke` low at an edge during the lock window sets the sticky `cke_viol` flag. Only `err_clr` clears it.
- R6: `rd_req` at an edge during the lock window sets the sticky `rd_err` flag. `err_clr` clears it, and a new set in the same cycle wins over the clear. `rd_req` outside the window leaves the flag at 0.
- R7: The write-recovery field is bits 11:9. The codes 001, 010, 011, 100, 101 and 110 mean 5, 6, 7, 8, 10 and 12 cycles. After an accepted write, `pre_ok` stays 0 for BURST_CYC plus that many cycles.
- R8: The codes 000 and 111 set `wr_illegal` to 1, and the recovery spacing used is then 12 cycles.
- R9: While `cke` is low, `rd_ok`, `wr_ok` and `pre_ok` are 0, and a `wr_req` is not accepted.
- R10: A write accepted while a recovery is still pending restarts the burst and recovery spacing from that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock-enable level |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_wdata | input | MR_W | Mode register write data |
| cfg_rdata | output | MR_W | Mode register readback |
| rd_req | input | 1 | Read command request |
| wr_req | input | 1 | Write command request |
| err_clr | input | 1 | Clears the sticky error flags |
| rd_ok | output | 1 | Read allowed |
| wr_ok | output | 1 | Write allowed |
| pre_ok | output | 1 | Precharge allowed |
| lock_busy | output | 1 | Lock window running |
| rd_err | output | 1 | Sticky read-during-lock error |
| cke_viol | output | 1 | Sticky clock-enable drop during lock |
| wr_illegal | output | 1 | Write-recovery field holds an illegal code |

## Verification
The bound assertions check the following on every cycle:
- the reset bit never reads back as set;
- a reset write blocks reads on the next cycle;
- the sticky flags set after a clock-enable drop or a read during the lock window;
- an accepted write closes the precharge window;
- low clock enable gates all three allow flags.

Only the bench scenarios can show the rest:
- the exact length of the lock window, both fresh and after a restart;
- the exact precharge spacing for each of the eight recovery codes, including the 12-cycle fallback;
- the restart of the spacing on a back-to-back write;
- that the clear pulse releases the sticky flags.

// File: rtl/mrg_pkg.sv
package mrg_pkg;
   localparam int DLL_RST_BIT = 8;
   localparam int WREC_LSB    = 9;
   localparam int WREC_FLD_W  = 3;
   localparam int WREC_MAX    = 12;
   localparam int WREC_W      = $clog2(WREC_MAX + 1);

   typedef struct packed {
      logic [WREC_W-1:0] cyc;
      logic              legal;
   } wrec_t;

   function automatic wrec_t wrec_decode(input logic [WREC_FLD_W-1:0] code);
      wrec_t r;
      r.legal = 1'b1;
      case (code)
         3'd1:    r.cyc = WREC_W'(5);
         3'd2:    r.cyc = WREC_W'(6);
         3'd3:    r.cyc = WREC_W'(7);
         3'd4:    r.cyc = WREC_W'(8);
         3'd5:    r.cyc = WREC_W'(10);
         3'd6:    r.cyc = WREC_W'(12);
         default: begin
            r.cyc   = WREC_W'(WREC_MAX);
            r.legal = 1'b0;
         end
      endcase
      return r;
   endfunction
endpackage

// File: rtl/mr_field_store.sv
module mr_field_store
   import mrg_pkg::*;
#(
   parameter int MR_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [MR_W-1:0] wdata,
   output logic [MR_W-1:0] rdata,
   output wrec_t           wrec
);
   localparam logic [MR_W-1:0] KEEP_MASK = ~(MR_W'(1) << DLL_RST_BIT);

   logic [MR_W-1:0] reg_q;

   always_ff @(posedge clk) begin
      if (!rst_n)  reg_q <= '0;
      else if (we) reg_q <= wdata & KEEP_MASK;
   end

   assign rdata = reg_q;
   assign wrec  = wrec_decode(reg_q[WREC_LSB +: WREC_FLD_W]);
endmodule

// File: rtl/dll_lock_timer.sv
module dll_lock_timer #(
   parameter int LOCK_CYC = 512
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic cke,
   output logic busy
);
   localparam int CW = $clog2(LOCK_CYC);
   localparam logic [CW-1:0] LAST = CW'(LOCK_CYC - 1);

   logic [CW-1:0] cnt_q;
   logic          busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
      end else if (busy_q) begin
         if (!cke)               cnt_q  <= '0;
         else if (cnt_q == LAST) busy_q <= 1'b0;
         else                    cnt_q  <= cnt_q + 1'b1;
      end
   end

   assign busy = busy_q;
endmodule

// File: rtl/wrec_timer.sv
module wrec_timer
   import mrg_pkg::*;
#(
   parameter int BURST_CYC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_fire,
   input  logic [WREC_W-1:0] rec_cyc,
   output logic              idle
);
   logic              burst_done;
   logic [WREC_W-1:0] rec_q;

   generate
      if (BURST_CYC > 0) begin : g_burst
         localparam int BW = $clog2(BURST_CYC + 1);
         logic [BW-1:0] burst_q;
         always_ff @(posedge clk) begin
            if (!rst_n)              burst_q <= '0;
            else if (wr_fire)        burst_q <= BW'(BURST_CYC);
            else if (burst_q != '0)  burst_q <= burst_q - 1'b1;
         end
         assign burst_done = (burst_q == '0);
      end else begin : g_no_burst
         assign burst_done = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)                          rec_q <= '0;
      else if (wr_fire)                    rec_q <= rec_cyc;
      else if (burst_done && rec_q != '0)  rec_q <= rec_q - 1'b1;
   end

   assign idle = burst_done && (rec_q == '0);
endmodule

// File: rtl/modereg_timing_guard.sv
module modereg_timing_guard
   import mrg_pkg::*;
#(
   parameter int MR_W      = 16,
   parameter int LOCK_CYC  = 512,
   parameter int BURST_CYC = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cke,
   input  logic            cfg_we,
   input  logic [MR_W-1:0] cfg_wdata,
   output logic [MR_W-1:0] cfg_rdata,
   input  logic            rd_req,
   input  logic            wr_req,
   input  logic            err_clr,
   output logic            rd_ok,
   output logic            wr_ok,
   output logic            pre_ok,
   output logic            lock_busy,
   output logic            rd_err,
   output logic            cke_viol,
   output logic            wr_illegal
);
   generate
      if (MR_W < WREC_LSB + WREC_FLD_W) begin : g_bad_width
         $error("MR_W too narrow for the recovery field");
      end
      if (LOCK_CYC < 2) begin : g_bad_lock
         $error("LOCK_CYC must be at least 2");
      end
      if (BURST_CYC < 0) begin : g_bad_burst
         $error("BURST_CYC must not be negative");
      end
   endgenerate

   wrec_t wrec;
   logic  dll_start;
   logic  wr_fire;
   logic  wr_idle;
   logic  rd_err_q;
   logic  cke_viol_q;

   assign dll_start = cfg_we && cfg_wdata[DLL_RST_BIT];

   mr_field_store #(.MR_W(MR_W)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .wdata (cfg_wdata),
      .rdata (cfg_rdata),
      .wrec  (wrec)
   );

   dll_lock_timer #(.LOCK_CYC(LOCK_CYC)) u_lock (
      .clk   (clk),
      .rst_n (rst_n),
      .start (dll_start),
      .cke   (cke),
      .busy  (lock_busy)
   );

   assign wr_ok   = cke;
   assign wr_fire = wr_req && wr_ok;

   wrec_timer #(.BURST_CYC(BURST_CYC)) u_wrec (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_fire (wr_fire),
      .rec_cyc (wrec.cyc),
      .idle    (wr_idle)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_err_q   <= 1'b0;
         cke_viol_q <= 1'b0;
      end else begin
         if (rd_req && lock_busy) rd_err_q <= 1'b1;
         else if (err_clr)        rd_err_q <= 1'b0;
         if (lock_busy && !cke)   cke_viol_q <= 1'b1;
         else if (err_clr)        cke_viol_q <= 1'b0;
      end
   end

   assign rd_ok      = cke && !lock_busy;
   assign pre_ok     = cke && wr_idle;
   assign rd_err     = rd_err_q;
   assign cke_viol   = cke_viol_q;
   assign wr_illegal = !wrec.legal;
endmodule

// File: rtl/modereg_timing_guard_chk.sv
module modereg_timing_guard_chk #(
   parameter int MR_W = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cke,
   input logic            cfg_we,
   input logic [MR_W-1:0] cfg_wdata,
   input logic [MR_W-1:0] cfg_rdata,
   input logic            rd_req,
   input logic            wr_req,
   input logic            wr_ok,
   input logic            rd_ok,
   input logic            pre_ok,
   input logic            lock_busy,
   input logic            rd_err,
   input logic            cke_viol
);
   p_selfclear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rdata[8] == 1'b0);

   p_lock_blocks_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we && cfg_wdata[8] |=> lock_busy && !rd_ok);

   p_cke_viol_r5: assert property (@(posedge clk) disable iff (!rst_n)
      lock_busy && !cke |=> cke_viol);

   p_rd_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req && lock_busy |=> rd_err);

   p_pre_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req && wr_ok |=> !pre_ok);

   p_cke_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !cke |-> !rd_ok && !wr_ok && !pre_ok);
endmodule

bind modereg_timing_guard modereg_timing_guard_chk #(.MR_W(MR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cke       (cke),
   .cfg_we    (cfg_we),
   .cfg_wdata (cfg_wdata),
   .cfg_rdata (cfg_rdata),
   .rd_req    (rd_req),
   .wr_req    (wr_req),
   .wr_ok     (wr_ok),
   .rd_ok     (rd_ok),
   .pre_ok    (pre_ok),
   .lock_busy (lock_busy),
   .rd_err    (rd_err),
   .cke_viol  (cke_viol)
);

// File: tb/modereg_timing_guard_tb.sv
`timescale 1ns/1ps
module modereg_timing_guard_tb;
   localparam int MR_W      = 16;
   localparam int LOCK_CYC  = 512;
   localparam int BURST_CYC = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cke = 1'b1;
   logic            cfg_we = 1'b0;
   logic [MR_W-1:0] cfg_wdata = '0;
   logic [MR_W-1:0] cfg_rdata;
   logic            rd_req = 1'b0;
   logic            wr_req = 1'b0;
   logic            err_clr = 1'b0;
   logic            rd_ok, wr_ok, pre_ok, lock_busy, rd_err, cke_viol, wr_illegal;

   int checks = 0;
   int failures = 0;
   int cycles = 0;

   always #2.5 clk = ~clk;

   modereg_timing_guard #(.MR_W(MR_W), .LOCK_CYC(LOCK_CYC), .BURST_CYC(BURST_CYC)) u_dut (
      .clk(clk), .rst_n(rst_n), .cke(cke), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .rd_req(rd_req), .wr_req(wr_req), .err_clr(err_clr),
      .rd_ok(rd_ok), .wr_ok(wr_ok), .pre_ok(pre_ok), .lock_busy(lock_busy),
      .rd_err(rd_err), .cke_viol(cke_viol), .wr_illegal(wr_illegal)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles == 150000) begin
         failures++;
         $display("FAIL watchdog act=%0d exp=<150000", cycles);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   // Caller stands at a negedge; returns at the negedge after the taking edge, settled.
   task automatic mr_write(input logic [MR_W-1:0] d);
      cfg_we = 1'b1; cfg_wdata = d;
      @(negedge clk); cfg_we = 1'b0; #1;
   endtask

   task automatic count_rd_low(output int n);
      n = 0;
      while (!rd_ok && n < 3000) begin
         n++;
         @(negedge clk); #1;
      end
   endtask

   task automatic do_write();
      wr_req = 1'b1;
      @(negedge clk); wr_req = 1'b0; #1;
   endtask

   task automatic count_pre_low(output int n);
      n = 0;
      while (!pre_ok && n < 100) begin
         n++;
         @(negedge clk); #1;
      end
   endtask

   function automatic int wrec_exp(input int code);
      case (code)
         1: return 5;  2: return 6;  3: return 7;
         4: return 8;  5: return 10; 6: return 12;
         default: return 12;
      endcase
   endfunction

   initial begin
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1; #1;
      // R1 reset state
      chk("R1 rdata", int'(cfg_rdata), 0);
      chk("R1 lock_busy", int'(lock_busy), 0);
      chk("R1 rd_err", int'(rd_err), 0);
      chk("R1 cke_viol", int'(cke_viol), 0);
      chk("R1 wr_illegal", int'(wr_illegal), 1);
      chk("R1 allow", int'({rd_ok, wr_ok, pre_ok}), 7);

      // R2 readback masks bit 8; R3 exact lock length
      @(negedge clk);
      mr_write(16'hFFFF);
      chk("R2 readback", int'(cfg_rdata), 16'hFEFF);
      chk("R3 lock_busy", int'(lock_busy), 1);
      count_rd_low(n);
      chk("R3 lock length", n, LOCK_CYC);
      chk("R5 no viol", int'(cke_viol), 0);

      // R2 other pattern, no lock when bit 8 clear
      mr_write(16'h0A5A & 16'hFEFF);
      chk("R2 readback2", int'(cfg_rdata), 16'h0A5A & 16'hFEFF);
      chk("R3 no lock", int'(lock_busy), 0);

      // R6 read outside window keeps flag clear
      rd_req = 1'b1; @(negedge clk); rd_req = 1'b0; #1;
      chk("R6 no err idle", int'(rd_err), 0);

      // R4 / R5 cke drop restarts lock
      mr_write(16'h0100);
      repeat (100) @(negedge clk);
      cke = 1'b0; @(negedge clk); cke = 1'b1; #1;
      chk("R5 viol set", int'(cke_viol), 1);
      count_rd_low(n);
      chk("R4 restart length", n, LOCK_CYC);
      err_clr = 1'b1; @(negedge clk); err_clr = 1'b0; #1;
      chk("R5 viol cleared", int'(cke_viol), 0);

      // R6 read during lock, set wins over clear, then clear
      mr_write(16'h0100);
      rd_req = 1'b1; @(negedge clk); rd_req = 1'b0; #1;
      chk("R6 err set", int'(rd_err), 1);
      rd_req = 1'b1; err_clr = 1'b1; @(negedge clk); rd_req = 1'b0; err_clr = 1'b0; #1;
      chk("R6 set wins", int'(rd_err), 1);
      err_clr = 1'b1; @(negedge clk); err_clr = 1'b0; #1;
      chk("R6 err cleared", int'(rd_err), 0);
      count_rd_low(n);

      // R7 / R8 sweep of all recovery codes
      for (int code = 0; code < 8; code++) begin
         mr_write(MR_W'(code << 9));
         chk((code == 0 || code == 7) ? "R8 illegal flag" : "R7 legal flag",
             int'(wr_illegal), (code == 0 || code == 7) ? 1 : 0);
         do_write();
         count_pre_low(n);
         chk((code == 0 || code == 7) ? "R8 spacing" : "R7 spacing",
             n, BURST_CYC + wrec_exp(code));
      end

      // R10 back-to-back write restarts spacing
      mr_write(16'h0200);
      do_write();
      repeat (3) @(negedge clk); #1;
      chk("R10 still closed", int'(pre_ok), 0);
      do_write();
      count_pre_low(n);
      chk("R10 restart", n, BURST_CYC + 5);

      // R9 cke low gates everything and blocks writes
      cke = 1'b0; #1;
      chk("R9 gated", int'({rd_ok, wr_ok, pre_ok}), 0);
      wr_req = 1'b1; @(negedge clk); wr_req = 1'b0; cke = 1'b1; #1;
      chk("R9 write ignored", int'(pre_ok), 1);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule